// File: doc/BRIEF.md
# Multiplierless Analytic Signal Filter

This block takes a stream of real, signed samples and produces the matching analytic signal: an in-phase and a quadrature output that together keep the positive-frequency content of the input and suppress the negative-frequency content. One complex output sample is produced for every accepted input sample. The passband is centred at a quarter of the sample rate, and the useful input band runs from roughly 0.065 to 0.435 of the sample rate.

The filter is a cascade of recursive sections. Each section pairs a comb (a term of the form 1 ± z^-N) with poles placed exactly on some of the comb's zeros. Every complex coefficient is 0, ±1 or ±j, so multiplying by j becomes a swap of the real and imaginary parts with one negation. The single real section uses a one-bit arithmetic right shift as its only scaling. Because each pole cancels a zero exactly in integer arithmetic, the whole cascade has a finite impulse response, and the real and imaginary outputs come from one complex filter with one gain.

One chain is six registered sections. The chain is instantiated `ORDER` times in cascade (default 2). A final stage applies a power-of-two scale and clamps the result to the output width.

Top module: `asf_analytic_filter`

## Requirements
- R1: A synchronous reset clears every delay, recursive and output register, so `out_i`, `out_q` and `out_valid` are 0 after reset. An all-zero input stream after reset yields all-zero outputs.
- R2: `out_valid` is high in the clock cycle after each cycle in which `in_valid` is high, and is low otherwise.
- R3: In a cycle with `in_valid` low, no section advances. The outputs hold their values, and the sample count used for latency advances only on accepted samples.
- R4: Output sample n equals the complex convolution of the input with a 21-tap impulse response h, taken at input index n-12. The latency is 12 accepted samples (6 per chain), and inputs before reset count as 0.
- R5: The first section of a chain is a comb 1 - z^-4 followed by a pole at +90 degrees (y = w + j*y[n-1]). Together they equal the FIR taps (1, j, -1, -j).
- R6: The second group of a chain is a comb 1 + z^-6, then a pole at +90 degrees, then a pole pair y = w + j*y[n-1] + y[n-2] (poles at 30 and 150 degrees). Together they equal the FIR taps (1, 2j, -2, -j).
- R7: The real section computes v = 4*x[n-2] - x[n-6] + (v[n-2] >>> 1) on both the real and imaginary parts. It equals the FIR taps (0, 0, 4, 0, 2), and its recursive state is always even, so the shift is exact.
- R8: Each output part equals floor(y / 2^11) of the full-width result, clamped to the range -32768..32767.
- R9: For a real input at a quarter of the sample rate, the steady-state output rotates by +90 degrees per sample: out_i[n+1] = -out_q[n] and out_q[n+1] = out_i[n].
- R10: After a single impulse followed by zeros, both outputs return exactly to 0 and stay there. No recursive section rings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input sample strobe; acts as the clock enable of every section |
| in_data | input | 16 | Real signed input sample |
| out_valid | output | 1 | Output sample strobe, one cycle after `in_valid` |
| out_i | output | 16 | In-phase (real) part of the analytic output |
| out_q | output | 16 | Quadrature (imaginary) part of the analytic output |

## Verification
The assertions check on every cycle four things:
- the strobe timing;
- that the outputs hold when no sample is accepted;
- that the clear after reset is complete;
- that the real section's state stays even and away from wrap-around, which is what makes the one-bit shift exact.

Whether the cascade as a whole has the intended impulse response cannot be seen from any single cycle. The same holds for the exact return to zero after an impulse, the clamping and the quarter-rate rotation. Those are shown only by the bench's scenarios, which compare each output against a convolution model built from the per-section tap lists.

// File: rtl/asf_pkg.sv
package asf_pkg;
  typedef enum logic {
    POLE_QUARTER = 1'b0,
    POLE_PAIR    = 1'b1
  } pole_kind_e;

  localparam int STAGES_PER_CHAIN = 6;
endpackage

// File: rtl/asf_comb.sv
module asf_comb #(
  parameter int W   = 32,
  parameter int LAG = 4,
  parameter bit SUB = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] x_re,
  input  logic signed [W-1:0] x_im,
  output logic signed [W-1:0] y_re,
  output logic signed [W-1:0] y_im
);
  logic signed [W-1:0] hist_re [LAG];
  logic signed [W-1:0] hist_im [LAG];

  function automatic logic signed [W-1:0] comb_op(input logic signed [W-1:0] a,
                                                  input logic signed [W-1:0] b);
    return SUB ? (a - b) : (a + b);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LAG; k++) begin
        hist_re[k] <= '0;
        hist_im[k] <= '0;
      end
      y_re <= '0;
      y_im <= '0;
    end else if (en) begin
      hist_re[0] <= x_re;
      hist_im[0] <= x_im;
      for (int k = 1; k < LAG; k++) begin
        hist_re[k] <= hist_re[k-1];
        hist_im[k] <= hist_im[k-1];
      end
      y_re <= comb_op(x_re, hist_re[LAG-1]);
      y_im <= comb_op(x_im, hist_im[LAG-1]);
    end
  end
endmodule

// File: rtl/asf_pole.sv
module asf_pole
  import asf_pkg::*;
#(
  parameter int         W    = 32,
  parameter pole_kind_e KIND = POLE_QUARTER
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] w_re,
  input  logic signed [W-1:0] w_im,
  output logic signed [W-1:0] y_re,
  output logic signed [W-1:0] y_im
);
  // j*(a + jb) = -b + ja : swap and negate, no multiplier
  function automatic logic signed [W-1:0] rot_re(input logic signed [W-1:0] a_im);
    return -a_im;
  endfunction

  generate
    if (KIND == POLE_QUARTER) begin : g_quarter
      // y[n] = w[n] + j*y[n-1]
      always_ff @(posedge clk) begin
        if (rst) begin
          y_re <= '0;
          y_im <= '0;
        end else if (en) begin
          y_re <= w_re + rot_re(y_im);
          y_im <= w_im + y_re;
        end
      end
    end else begin : g_pair
      // y[n] = w[n] + j*y[n-1] + y[n-2]
      logic signed [W-1:0] y2_re, y2_im;
      always_ff @(posedge clk) begin
        if (rst) begin
          y_re  <= '0;
          y_im  <= '0;
          y2_re <= '0;
          y2_im <= '0;
        end else if (en) begin
          y_re  <= w_re + rot_re(y_im) + y2_re;
          y_im  <= w_im + y_re + y2_im;
          y2_re <= y_re;
          y2_im <= y_im;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/asf_edge_shaper.sv
module asf_edge_shaper #(
  parameter int W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic signed [W-1:0] x_re,
  input  logic signed [W-1:0] x_im,
  output logic signed [W-1:0] v_re,
  output logic signed [W-1:0] v_im
);
  localparam int HIST = 6;

  logic signed [W-1:0] xh_re [HIST];
  logic signed [W-1:0] xh_im [HIST];
  logic signed [W-1:0] v2_re, v2_im;

  // v[n] = 4*x[n-2] - x[n-6] + v[n-2]/2 ; equals 4*x[n-2] + 2*x[n-4]
  function automatic logic signed [W-1:0] shape(input logic signed [W-1:0] x2,
                                                input logic signed [W-1:0] x6,
                                                input logic signed [W-1:0] v2);
    return (x2 <<< 2) - x6 + (v2 >>> 1);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < HIST; k++) begin
        xh_re[k] <= '0;
        xh_im[k] <= '0;
      end
      v_re  <= '0;
      v_im  <= '0;
      v2_re <= '0;
      v2_im <= '0;
    end else if (en) begin
      xh_re[0] <= x_re;
      xh_im[0] <= x_im;
      for (int k = 1; k < HIST; k++) begin
        xh_re[k] <= xh_re[k-1];
        xh_im[k] <= xh_im[k-1];
      end
      v_re  <= shape(xh_re[1], xh_re[5], v2_re);
      v_im  <= shape(xh_im[1], xh_im[5], v2_im);
      v2_re <= v_re;
      v2_im <= v_im;
    end
  end

  // R7
  // even_state_chk: the shifted state must be even for the halving to be exact
  even_state_chk: assert property (@(posedge clk) disable iff (rst)
    (v_re[0] == 1'b0) && (v_im[0] == 1'b0) && (v2_re[0] == 1'b0) && (v2_im[0] == 1'b0));

  // R7
  // no_wrap_chk: guard bits keep the state clear of two's-complement wrap
  no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (v_re[W-1] == v_re[W-2]) && (v_im[W-1] == v_im[W-2]));
endmodule

// File: rtl/asf_analytic_filter.sv
module asf_analytic_filter
  import asf_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int OUT_W     = 16,
  parameter int GUARD     = 16,
  parameter int ORDER     = 2,
  parameter int OUT_SHIFT = 11
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);
  localparam int ACC_W = IN_W + GUARD;
  localparam int LATENCY_SAMPLES = STAGES_PER_CHAIN * ORDER;
  localparam logic signed [ACC_W-1:0] OUT_MAX =
    {{(ACC_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] OUT_MIN =
    {{(ACC_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  logic signed [ACC_W-1:0] link_re [ORDER+1];
  logic signed [ACC_W-1:0] link_im [ORDER+1];

  assign link_re[0] = {{(ACC_W-IN_W){in_data[IN_W-1]}}, in_data};
  assign link_im[0] = '0;

  generate
    for (genvar g = 0; g < ORDER; g++) begin : g_chain
      logic signed [ACC_W-1:0] s_re [5];
      logic signed [ACC_W-1:0] s_im [5];

      asf_comb #(.W(ACC_W), .LAG(4), .SUB(1'b1)) u_comb4 (
        .clk(clk), .rst(rst), .en(in_valid),
        .x_re(link_re[g]), .x_im(link_im[g]), .y_re(s_re[0]), .y_im(s_im[0]));

      asf_pole #(.W(ACC_W), .KIND(POLE_QUARTER)) u_pole_a (
        .clk(clk), .rst(rst), .en(in_valid),
        .w_re(s_re[0]), .w_im(s_im[0]), .y_re(s_re[1]), .y_im(s_im[1]));

      asf_comb #(.W(ACC_W), .LAG(6), .SUB(1'b0)) u_comb6 (
        .clk(clk), .rst(rst), .en(in_valid),
        .x_re(s_re[1]), .x_im(s_im[1]), .y_re(s_re[2]), .y_im(s_im[2]));

      asf_pole #(.W(ACC_W), .KIND(POLE_QUARTER)) u_pole_b (
        .clk(clk), .rst(rst), .en(in_valid),
        .w_re(s_re[2]), .w_im(s_im[2]), .y_re(s_re[3]), .y_im(s_im[3]));

      asf_pole #(.W(ACC_W), .KIND(POLE_PAIR)) u_pole_pair (
        .clk(clk), .rst(rst), .en(in_valid),
        .w_re(s_re[3]), .w_im(s_im[3]), .y_re(s_re[4]), .y_im(s_im[4]));

      asf_edge_shaper #(.W(ACC_W)) u_shaper (
        .clk(clk), .rst(rst), .en(in_valid),
        .x_re(s_re[4]), .x_im(s_im[4]), .v_re(link_re[g+1]), .v_im(link_im[g+1]));
    end
  endgenerate

  function automatic logic signed [OUT_W-1:0] scale_sat(input logic signed [ACC_W-1:0] v);
    logic signed [ACC_W-1:0] s;
    s = v >>> OUT_SHIFT;
    if (s > OUT_MAX) s = OUT_MAX;
    else if (s < OUT_MIN) s = OUT_MIN;
    return s[OUT_W-1:0];
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_i <= scale_sat(link_re[ORDER]);
        out_q <= scale_sat(link_im[ORDER]);
      end
    end
  end

  // R1
  // reset_clear_chk: one cycle after reset the outputs are cleared
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (out_i == '0) && (out_q == '0) && !out_valid);

  // R2
  // valid_follow_chk: an output strobe only after an accepted sample
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid));

  // R3
  // out_hold_chk: no accepted sample, no output change
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_i) && $stable(out_q));

  initial begin
    if (LATENCY_SAMPLES != 6 * ORDER) $error("latency derivation mismatch");
  end
endmodule

// File: tb/tb_asf_analytic_filter.sv
module tb_asf_analytic_filter;
  localparam int LAT   = 12;
  localparam int NTAP  = 21;
  localparam int SHIFT = 11;

  logic clk = 1'b0;
  logic rst;
  logic in_valid;
  logic signed [15:0] in_data;
  logic out_valid;
  logic signed [15:0] out_i, out_q;

  int tests = 0;
  int fails = 0;
  int hr [NTAP];
  int hi [NTAP];
  int xh [0:1023];
  int n_in = 0;

  always #10 clk = ~clk;

  asf_analytic_filter dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q));

  task automatic check(input string req, input longint act, input longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Taps of one chain from the per-section lists (R5, R6, R7), then the chain squared
  task automatic build_taps();
    int ar [4] = '{1, 0, -1, 0};
    int ai [4] = '{0, 1, 0, -1};
    int br [4] = '{1, 0, -2, 0};
    int bi [4] = '{0, 2, 0, -1};
    int cr [5] = '{0, 0, 4, 0, 2};
    int abr [7];
    int abi [7];
    int chr [11];
    int chi [11];
    foreach (abr[k]) begin abr[k] = 0; abi[k] = 0; end
    foreach (chr[k]) begin chr[k] = 0; chi[k] = 0; end
    foreach (hr[k])  begin hr[k] = 0;  hi[k] = 0;  end
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        abr[a+b] += ar[a]*br[b] - ai[a]*bi[b];
        abi[a+b] += ar[a]*bi[b] + ai[a]*br[b];
      end
    for (int a = 0; a < 7; a++)
      for (int c = 0; c < 5; c++) begin
        chr[a+c] += abr[a]*cr[c];
        chi[a+c] += abi[a]*cr[c];
      end
    for (int a = 0; a < 11; a++)
      for (int b = 0; b < 11; b++) begin
        hr[a+b] += chr[a]*chr[b] - chi[a]*chi[b];
        hi[a+b] += chr[a]*chi[b] + chi[a]*chr[b];
      end
  endtask

  function automatic longint model(input int m, input bit imag);
    longint acc = 0;
    if (m < 0) return 0;
    for (int k = 0; k < NTAP; k++)
      if (m - k >= 0) acc += longint'(imag ? hi[k] : hr[k]) * longint'(xh[m-k]);
    acc = acc >>> SHIFT;
    if (acc > 32767) acc = 32767;
    if (acc < -32768) acc = -32768;
    return acc;
  endfunction

  // called at a negedge; returns at the negedge after the capturing edge
  task automatic push(input int v, input string req);
    in_valid = 1'b1;
    in_data  = 16'(v);
    xh[n_in] = v;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " strobe"}, longint'(out_valid), 1);
    check({req, " I"}, longint'(out_i), model(n_in - LAT, 1'b0));
    check({req, " Q"}, longint'(out_q), model(n_in - LAT, 1'b1));
    n_in++;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    in_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    n_in = 0;
    foreach (xh[k]) xh[k] = 0;
  endtask

  task automatic t_reset();
    do_reset();
    check("R1 I after reset", longint'(out_i), 0);
    check("R1 Q after reset", longint'(out_q), 0);
    check("R1 strobe after reset", longint'(out_valid), 0);
    for (int k = 0; k < 20; k++) push(0, "R1 zero stream");
  endtask

  task automatic t_impulse();
    do_reset();
    push(32767, "R4 R5 R6 R7 impulse");
    for (int k = 0; k < 45; k++) push(0, "R4 R5 R6 R7 impulse tail");
    check("R10 I settles to zero", longint'(out_i), 0);
    check("R10 Q settles to zero", longint'(out_q), 0);
  endtask

  task automatic t_gaps();
    int hold_i, hold_q;
    do_reset();
    for (int k = 0; k < 30; k++) begin
      push((k * 7919) % 20000 - 10000, "R3 R4 gapped stream");
      hold_i = out_i;
      hold_q = out_q;
      repeat (k % 3) begin
        @(negedge clk);
        check("R2 no strobe while idle", longint'(out_valid), 0);
        check("R3 I held while idle", longint'(out_i), hold_i);
        check("R3 Q held while idle", longint'(out_q), hold_q);
      end
    end
  endtask

  task automatic t_tone();
    int pi_prev, pq_prev;
    int pat [4] = '{10000, 0, -10000, 0};
    do_reset();
    for (int k = 0; k < 60; k++) begin
      pi_prev = out_i;
      pq_prev = out_q;
      push(pat[k % 4], "R4 quarter-rate tone");
      if (k >= 40) begin
        check("R9 rotation I", longint'(out_i), -longint'(pq_prev));
        check("R9 rotation Q", longint'(out_q), longint'(pi_prev));
      end
    end
  endtask

  task automatic t_saturate();
    do_reset();
    for (int k = 0; k < NTAP; k++)
      push(hr[NTAP-1-k] > 0 ? 30000 : (hr[NTAP-1-k] < 0 ? -30000 : 0), "R8 clamp");
    for (int k = 0; k < LAT + 2; k++) push(0, "R8 clamp drain");
  endtask

  task automatic t_random();
    logic [15:0] lfsr = 16'hACE1;
    do_reset();
    for (int k = 0; k < 150; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      push(int'($signed(lfsr)), "R4 pseudo-random stream");
    end
  endtask

  task automatic t_reset_mid();
    do_reset();
    for (int k = 0; k < 10; k++) push(20000 - k * 3000, "R4 pre-reset stream");
    do_reset();
    for (int k = 0; k < 25; k++) push(0, "R1 zeros after mid-stream reset");
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst = 1'b1;
    in_valid = 1'b0;
    in_data = '0;
    build_taps();
    t_reset();
    t_impulse();
    t_gaps();
    t_tone();
    t_saturate();
    t_random();
    t_reset_mid();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule